// File: doc/BRIEF.md
# Fan Rotor Lock and Standby Supervisor

This block watches a single-phase fan drive for two conditions: a rotor that has stopped turning while drive is applied, and a speed command so close to zero that the fan should park. Two digital timers do the work. A stall timer counts up every cycle while the drive runs, and every tachometer edge (`fg_edge`) clears it. If no edge arrives before the stall timer reaches its upper threshold, the supervisor enters lock protection. In lock protection the upper output switches stay off and the lock indicator is released high. During protection the stall timer counts back down at a reduced rate. When it reaches its lower threshold, the block issues a one-cycle soft-start restart and tries again, so retries repeat on their own.

An idle timer runs while the PWM controller flags a near-zero duty (`low_duty`) and clears as soon as the flag drops. When the idle timer reaches its limit, the supervisor parks in standby. In standby the stall timer is held at zero and the lock indicator is pulled low. When `low_duty` drops, the block leaves standby at once with a restart pulse.

The controller has three named states. DRIVE is normal rotation, LOCKED is protection, and IDLE is standby. The transitions are:
- Stall trip: DRIVE to LOCKED.
- Retry: LOCKED to DRIVE, with a restart pulse.
- Park: DRIVE or LOCKED to IDLE.
- Wake: IDLE to DRIVE, with a restart pulse.
- Disable: any state to DRIVE, with everything cleared, while `enable` is low.

Top module: `rotor_guard`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `lock_protect`, `standby`, `restart` and `rd_pull_low` are all 0. Both timers are held at zero, so neither stall nor park can occur during that time.
- R2: In DRIVE the stall timer counts up by one per cycle and is cleared by any cycle with `fg_edge`=1. Starting from zero with no edge, `lock_protect` rises LOCK_HI+1 cycles later.
- R3: On the stall trip `lock_protect` goes to 1 and `rd_pull_low` goes to 0 (released). The trip is not taken in a cycle where `fg_edge`=1, even if the timer is at LOCK_HI.
- R4: In LOCKED the stall timer counts down by one every RETRY_DIV cycles, and `fg_edge` is ignored. LOCKED lasts (LOCK_HI-LOCK_LO)*RETRY_DIV+1 cycles and then ends with the retry.
- R5: `rd_pull_low` goes to 1 in the cycle after the first `fg_edge` seen in DRIVE. This holds after reset and after a retry. Until that edge, the indicator stays released.
- R6: The idle timer counts cycles with `low_duty`=1 and is cleared by any cycle with `low_duty`=0. `standby` rises after IDLE_HI+1 consecutive cycles of `low_duty`=1.
- R7: In IDLE, `rd_pull_low`=1 and the stall timer is held at zero. After a wake, a full LOCK_HI+1 cycles without edges pass before a stall trip.
- R8: In IDLE, a cycle with `low_duty`=0 wakes the block. In the next cycle `standby`=0 and `restart`=1.
- R9: Park takes priority over stall. When the idle timer completes while LOCKED, the block goes to IDLE with `lock_protect`=0 and `rd_pull_low`=1. IDLE never moves directly to LOCKED.
- R10: `restart` is a single-cycle pulse. It is raised only by a retry or a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock; one tick of both timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Drive enabled; low clears and holds the supervisor |
| fg_edge | input | 1 | One-cycle pulse per tachometer transition |
| low_duty | input | 1 | Commanded duty is near zero |
| lock_protect | output | 1 | Stall protection active; upper switches off |
| standby | output | 1 | Parked in standby |
| restart | output | 1 | One-cycle soft-start trigger |
| rd_pull_low | output | 1 | Open-drain lock indicator: 1 pulls low (running), 0 releases high |

## Verification
The assertions assume that `fg_edge`, `low_duty` and `enable` are synchronous to `clk`. They also assume that a stall trip is only possible from a state that has already counted since reset, so that `$rose(lock_protect)` always has a valid previous cycle to look at. The stimulus changes every input one time unit after a rising edge and holds it for whole cycles. `fg_edge` is given either as single-cycle pulses or as a level held high to pin the stall timer at zero. The thresholds are scaled down so that every trip, retry, park and wake happens within a few hundred cycles.

// File: rtl/rotor_guard_pkg.sv
package rotor_guard_pkg;
    typedef enum logic [1:0] {
        GS_DRIVE  = 2'd0,
        GS_LOCKED = 2'd1,
        GS_IDLE   = 2'd2
    } guard_state_e;
endpackage

// File: rtl/rg_stall_timer.sv
module rg_stall_timer #(
    parameter int LOCK_HI   = 4095,
    parameter int LOCK_LO   = 1024,
    parameter int RETRY_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic charge,
    input  logic discharge,
    input  logic fg_edge,
    output logic at_high,
    output logic at_low
);
    localparam int CW = $clog2(LOCK_HI + 1);
    localparam int PW = (RETRY_DIV > 1) ? $clog2(RETRY_DIV) : 1;
    localparam logic [CW-1:0] HI_V  = CW'(LOCK_HI);
    localparam logic [CW-1:0] LO_V  = CW'(LOCK_LO);
    localparam logic [PW-1:0] DIV_V = PW'(RETRY_DIV - 1);

    logic [CW-1:0] cnt;
    logic [PW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            pre <= '0;
        end else if (clear) begin
            cnt <= '0;
            pre <= '0;
        end else if (charge) begin
            pre <= '0;
            if (fg_edge)
                cnt <= '0;
            else if (cnt != HI_V)
                cnt <= cnt + 1'b1;
        end else if (discharge) begin
            if (pre == DIV_V) begin
                pre <= '0;
                if (cnt > LO_V)
                    cnt <= cnt - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end else begin
            pre <= '0;
        end
    end

    assign at_high = (cnt == HI_V);
    assign at_low  = (cnt <= LO_V);
endmodule

// File: rtl/rg_idle_timer.sv
module rg_idle_timer #(
    parameter int IDLE_HI = 2047
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic at_limit
);
    localparam int CW = $clog2(IDLE_HI + 1);
    localparam logic [CW-1:0] LIM_V = CW'(IDLE_HI);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (cnt != LIM_V)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LIM_V);
endmodule

// File: rtl/rg_fsm.sv
module rg_fsm
    import rotor_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         fg_edge,
    input  logic         low_duty,
    input  logic         lock_high,
    input  logic         lock_low,
    input  logic         idle_hit,
    output guard_state_e state,
    output logic         restart,
    output logic         rd_low
);
    guard_state_e nxt;
    logic         restart_n;

    always_comb begin
        nxt       = state;
        restart_n = 1'b0;
        if (!enable) begin
            nxt = GS_DRIVE;
        end else begin
            unique case (state)
                GS_DRIVE: begin
                    if (idle_hit)
                        nxt = GS_IDLE;
                    else if (lock_high && !fg_edge)
                        nxt = GS_LOCKED;
                end
                GS_LOCKED: begin
                    if (idle_hit) begin
                        nxt = GS_IDLE;
                    end else if (lock_low) begin
                        nxt       = GS_DRIVE;
                        restart_n = 1'b1;
                    end
                end
                GS_IDLE: begin
                    if (!low_duty) begin
                        nxt       = GS_DRIVE;
                        restart_n = 1'b1;
                    end
                end
                default: nxt = GS_DRIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= GS_DRIVE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart <= 1'b0;
            rd_low  <= 1'b0;
        end else begin
            restart <= restart_n;
            if (!enable)
                rd_low <= 1'b0;
            else if (nxt == GS_IDLE)
                rd_low <= 1'b1;
            else if (nxt == GS_LOCKED)
                rd_low <= 1'b0;
            else if (state == GS_DRIVE && fg_edge)
                rd_low <= 1'b1;
        end
    end
endmodule

// File: rtl/rotor_guard.sv
module rotor_guard
    import rotor_guard_pkg::*;
#(
    parameter int LOCK_HI   = 4095,
    parameter int LOCK_LO   = 1024,
    parameter int RETRY_DIV = 10,
    parameter int IDLE_HI   = 2047
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fg_edge,
    input  logic low_duty,
    output logic lock_protect,
    output logic standby,
    output logic restart,
    output logic rd_pull_low
);
    guard_state_e state;
    logic lock_high, lock_low, idle_hit;

    rg_stall_timer #(
        .LOCK_HI  (LOCK_HI),
        .LOCK_LO  (LOCK_LO),
        .RETRY_DIV(RETRY_DIV)
    ) i_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!enable || state == GS_IDLE),
        .charge   (state == GS_DRIVE),
        .discharge(state == GS_LOCKED),
        .fg_edge  (fg_edge),
        .at_high  (lock_high),
        .at_low   (lock_low)
    );

    rg_idle_timer #(
        .IDLE_HI(IDLE_HI)
    ) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable || !low_duty),
        .at_limit(idle_hit)
    );

    rg_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fg_edge  (fg_edge),
        .low_duty (low_duty),
        .lock_high(lock_high),
        .lock_low (lock_low),
        .idle_hit (idle_hit),
        .state    (state),
        .restart  (restart),
        .rd_low   (rd_pull_low)
    );

    assign lock_protect = (state == GS_LOCKED);
    assign standby      = (state == GS_IDLE);
endmodule

// File: rtl/rotor_guard_chk.sv
module rotor_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fg_edge,
    input logic low_duty,
    input logic lock_protect,
    input logic standby,
    input logic restart,
    input logic rd_pull_low
);
    p_disable_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!lock_protect && !standby && !restart && !rd_pull_low));

    p_lock_releases_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_protect |-> !rd_pull_low);

    p_trip_without_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_protect) |-> !$past(fg_edge));

    p_standby_pulls_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> rd_pull_low);

    p_restart_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(lock_protect || standby) && !lock_protect && !standby));

    p_idle_not_to_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !lock_protect);

    p_restart_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);
endmodule

bind rotor_guard rotor_guard_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .fg_edge     (fg_edge),
    .low_duty    (low_duty),
    .lock_protect(lock_protect),
    .standby     (standby),
    .restart     (restart),
    .rd_pull_low (rd_pull_low)
);

// File: tb/test_rotor_guard.sv
module test_rotor_guard;
    localparam int CLK_PERIOD = 10;
    localparam int HI  = 40;
    localparam int LO  = 10;
    localparam int DIV = 4;
    localparam int IH  = 20;
    localparam int NV  = 14;

    // {fg, low_duty, enable, ticks[7:0], exp lock, standby, restart, rd}
    localparam logic [14:0] VECS [0:NV-1] = '{
        {1'b1, 1'b0, 1'b1, 8'd3,  4'b0001},
        {1'b1, 1'b1, 1'b1, 8'd20, 4'b0001},
        {1'b1, 1'b1, 1'b1, 8'd1,  4'b0101},
        {1'b0, 1'b1, 1'b1, 8'd50, 4'b0101},
        {1'b0, 1'b0, 1'b1, 8'd1,  4'b0011},
        {1'b0, 1'b0, 1'b1, 8'd1,  4'b0001},
        {1'b0, 1'b0, 1'b1, 8'd39, 4'b0001},
        {1'b0, 1'b0, 1'b1, 8'd1,  4'b1000},
        {1'b0, 1'b1, 1'b1, 8'd20, 4'b1000},
        {1'b0, 1'b1, 1'b1, 8'd1,  4'b0101},
        {1'b0, 1'b0, 1'b1, 8'd1,  4'b0011},
        {1'b0, 1'b0, 1'b0, 8'd1,  4'b0000},
        {1'b0, 1'b1, 1'b0, 8'd60, 4'b0000},
        {1'b0, 1'b0, 1'b1, 8'd2,  4'b0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic fg_edge = 1'b0;
    logic low_duty = 1'b0;
    logic lock_protect, standby, restart, rd_pull_low;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotor_guard #(
        .LOCK_HI(HI), .LOCK_LO(LO), .RETRY_DIV(DIV), .IDLE_HI(IH)
    ) i_rotor_guard (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fg_edge(fg_edge),
        .low_duty(low_duty), .lock_protect(lock_protect), .standby(standby),
        .restart(restart), .rd_pull_low(rd_pull_low)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [3:0] exp);
        chk(req, "lock_protect", lock_protect, exp[3]);
        chk(req, "standby", standby, exp[2]);
        chk(req, "restart", restart, exp[1]);
        chk(req, "rd_pull_low", rd_pull_low, exp[0]);
    endtask

    task automatic do_reset();
        fg_edge = 1'b0; low_duty = 1'b0; enable = 1'b1;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    function automatic string row_tag(input int r);
        case (r)
            0:       return "R5";
            1, 2:    return "R6";
            3, 7:    return "R7";
            4, 10:   return "R8";
            5:       return "R10";
            6:       return "R2";
            8, 9:    return "R9";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1;
        chk_all("R1", 4'b0000);            // during reset
        do_reset();
        chk_all("R1", 4'b0000);

        for (int r = 0; r < NV; r++) begin
            fg_edge  = VECS[r][14];
            low_duty = VECS[r][13];
            enable   = VECS[r][12];
            tick(int'(VECS[r][11:4]));
            chk_all(row_tag(r), VECS[r][3:0]);
        end

        // R2: an edge restarts the stall window
        do_reset();
        tick(30);
        fg_edge = 1'b1; tick(1); fg_edge = 1'b0;
        tick(HI);
        chk("R2", "no trip before window", lock_protect, 1'b0);
        tick(1);
        chk("R2", "trip after window", lock_protect, 1'b1);
        chk("R3", "rd released on trip", rd_pull_low, 1'b0);

        // R4: retry timing, edges ignored while locked
        tick(60);
        fg_edge = 1'b1; tick(1); fg_edge = 1'b0;
        tick((HI - LO) * DIV - 61);
        chk("R4", "still locked", lock_protect, 1'b1);
        chk("R4", "no early restart", restart, 1'b0);
        tick(1);
        chk("R4", "retry ends lock", lock_protect, 1'b0);
        chk("R10", "restart on retry", restart, 1'b1);
        chk("R5", "rd released at retry", rd_pull_low, 1'b0);
        tick(1);
        chk("R10", "restart single cycle", restart, 1'b0);
        tick(5);
        chk("R5", "rd released before edge", rd_pull_low, 1'b0);
        fg_edge = 1'b1; tick(1); fg_edge = 1'b0;
        chk("R5", "rd low after first edge", rd_pull_low, 1'b1);

        // R3: edge in the trip cycle blocks the trip
        do_reset();
        tick(HI);
        fg_edge = 1'b1; tick(1); fg_edge = 1'b0;
        chk("R3", "edge at threshold blocks trip", lock_protect, 1'b0);
        tick(HI);
        chk("R3", "window restarted", lock_protect, 1'b0);
        tick(1);
        chk("R3", "trip after restarted window", lock_protect, 1'b1);

        // R6: a gap in low_duty restarts the idle count
        do_reset();
        fg_edge = 1'b1;
        low_duty = 1'b1; tick(15);
        low_duty = 1'b0; tick(1);
        low_duty = 1'b1; tick(IH);
        chk("R6", "no park before limit", standby, 1'b0);
        tick(1);
        chk("R6", "park at limit", standby, 1'b1);

        // R1: reset from standby clears everything
        rst_n = 1'b0; #1;
        chk_all("R1", 4'b0000);
        rst_n = 1'b1; fg_edge = 1'b0; low_duty = 1'b0;
        tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule